// File: doc/BRIEF.md
# Out-of-Band Burst Pattern Detector

This block watches a one-bit line-activity level that an analog squelch circuit produces, sampled on a fixed reference clock. It times each stretch of activity (a burst) and each stretch of silence (a gap). It recognises two out-of-band signalling patterns by the length of the gaps between bursts. The reset/init pattern uses a long nominal gap. Reset and init look the same on the wire and differ only in which side sends them. The wake pattern uses a shorter gap. A pattern is qualified when four consecutive acceptable bursts are separated by gaps inside that pattern's window.

Each qualified pattern gives a single-cycle pulse on its own output. A long quiet stretch after a detection means the far end has released the pattern. This is reported as a single-cycle release pulse, and the detectors are re-armed for the next pattern. All limits are parameters counted in reference-clock cycles. The release threshold must exceed both gap maxima.

Top module: `oob_pattern_detector`

## Requirements
- R1: During reset and after its release, with the line quiet, `init_det_o`, `wake_det_o` and `release_o` are all 0.
- R2: Four bursts of at least BURST_MIN high samples, each pair separated by between INIT_GAP_MIN and INIT_GAP_MAX low samples (both limits inclusive), make `init_det_o` high for exactly one cycle. That cycle is the one after the clock edge that samples the first low after the fourth burst.
- R3: A run of only three such bursts, followed by a long quiet stretch, produces no detect pulse.
- R4: A gap outside the init window clears the init burst count, and a gap equal to either window limit is accepted. After a rejected gap, counting starts again at the next burst, and four further good bursts are needed.
- R5: The wake pattern follows the R2 and R4 rules with its own window, WAKE_GAP_MIN to WAKE_GAP_MAX, and pulses `wake_det_o`.
- R6: A burst with fewer than BURST_MIN high samples is not counted and clears the count of both patterns.
- R7: After a pattern has pulsed, more qualifying bursts of that pattern produce no further pulse until a release has been reported.
- R8: When a detection has occurred since the last release, `release_o` is high for one cycle, in the cycle after the RELEASE_QUIET-th consecutive low sample. Both patterns are then re-armed. With no detection pending, no release pulse occurs.
- R9: The gap measurement saturates, so a quiet stretch of any length, including one longer than the counter range, is never taken as an in-window gap.
- R10: When the two windows overlap and every gap falls inside both, `init_det_o` and `wake_det_o` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference sampling clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_active_i | input | 1 | Squelch output: 1 while a burst is present on the line |
| init_det_o | output | 1 | One-cycle pulse when a reset/init pattern qualifies |
| wake_det_o | output | 1 | One-cycle pulse when a wake pattern qualifies |
| release_o | output | 1 | One-cycle pulse when a detected pattern has been released |

## Verification
Two functions can complete in the same cycle: init qualification and wake qualification. This happens when a single burst end finishes both chains. The bench widens the wake window so that it overlaps the init window, then sends bursts whose gaps lie inside the overlap. A reference model that tracks each pattern independently predicts both pulses in one cycle, and every output is compared against that prediction on every cycle. Random sequences mix gaps from both windows, the overlap and out-of-window lengths, so partial chains of one pattern are regularly cut by gaps that keep the other pattern's chain alive.

// File: rtl/oob_pkg.sv
package oob_pkg;

  // Number of in-window bursts required to qualify a pattern
  localparam int unsigned QUAL_BURSTS = 4;

  // Pattern slots handled by the per-pattern qualifiers
  localparam int unsigned NUM_PAT = 2;

  typedef enum int unsigned {
    PAT_INIT = 0,
    PAT_WAKE = 1
  } pat_e;

  // Events produced by the run-length meter for one sample
  typedef struct packed {
    logic burst_end;  // a high run just finished
    logic idle_end;   // a low run just finished
    logic quiet_hit;  // the current low run reaches the release threshold
  } run_evt_t;

endpackage

// File: rtl/oob_rst_sync.sv
module oob_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/oob_run_meter.sv
module oob_run_meter
  import oob_pkg::*;
#(
  parameter int unsigned CNT_MAX = 40,
  parameter int unsigned QUIET   = 40,
  parameter int unsigned CNT_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sig_i,
  output run_evt_t         evt_o,
  output logic [CNT_W-1:0] run_len_o
);

  localparam logic [CNT_W-1:0] RUN_TOP   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] QUIET_PRE = CNT_W'(QUIET - 1);
  localparam logic [CNT_W-1:0] RUN_ONE   = CNT_W'(1);

  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic             edge_ev;
  logic             run_en;

  // next-state
  always_comb begin
    edge_ev = sig_i ^ lvl_q;
    lvl_d   = sig_i;
    run_en  = edge_ev | (run_q != RUN_TOP);
    run_d   = edge_ev ? RUN_ONE : (run_q + RUN_ONE);
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lvl_q <= 1'b0;
      run_q <= RUN_TOP;
    end else begin
      lvl_q <= lvl_d;
      if (run_en) begin
        run_q <= run_d;
      end
    end
  end

  always_comb begin
    evt_o.burst_end = edge_ev & lvl_q;
    evt_o.idle_end  = edge_ev & ~lvl_q;
    evt_o.quiet_hit = ~edge_ev & ~lvl_q & (run_q == QUIET_PRE);
  end

  assign run_len_o = run_q;

  // A run that continues never shrinks: the measurement holds at its ceiling
  AST_RUN_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$past(edge_ev) |-> (run_q >= $past(run_q))); // R9

endmodule

// File: rtl/oob_pattern_qual.sv
module oob_pattern_qual #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned GAP_MIN   = 12,
  parameter int unsigned GAP_MAX   = 36,
  parameter int unsigned BURST_MIN = 2,
  parameter int unsigned QUAL_N    = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             burst_end_i,
  input  logic             idle_end_i,
  input  logic [CNT_W-1:0] run_len_i,
  input  logic             rearm_i,
  output logic             det_o,
  output logic             armed_o
);

  localparam int unsigned      QW    = $clog2(QUAL_N + 1);
  localparam logic [CNT_W-1:0] G_LO  = CNT_W'(GAP_MIN);
  localparam logic [CNT_W-1:0] G_HI  = CNT_W'(GAP_MAX);
  localparam logic [CNT_W-1:0] B_LO  = CNT_W'(BURST_MIN);
  localparam logic [QW-1:0]    QFULL = QW'(QUAL_N);
  localparam logic [QW-1:0]    QLAST = QW'(QUAL_N - 1);
  localparam logic [QW-1:0]    QONE  = QW'(1);

  logic [QW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          det_q, det_d;
  logic          gap_ok, burst_ok, upd_en;

  // next-state
  always_comb begin
    gap_ok   = (run_len_i >= G_LO) && (run_len_i <= G_HI);
    burst_ok = (run_len_i >= B_LO);
    upd_en   = rearm_i | idle_end_i | burst_end_i;
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    det_d    = 1'b0;
    if (rearm_i) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (idle_end_i) begin
      if (!gap_ok) begin
        cnt_d = '0;
      end
    end else if (burst_end_i) begin
      if (!burst_ok) begin
        cnt_d = '0;
      end else begin
        if (cnt_q != QFULL) begin
          cnt_d = cnt_q + QONE;
        end
        if ((cnt_q == QLAST) && armed_q) begin
          det_d   = 1'b1;
          armed_d = 1'b0;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      det_q   <= 1'b0;
    end else begin
      det_q <= det_d;
      if (upd_en) begin
        cnt_q   <= cnt_d;
        armed_q <= armed_d;
      end
    end
  end

  assign det_o   = det_q;
  assign armed_o = armed_q;

  AST_DET_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    det_q |=> !det_q); // R2

  AST_DET_AFTER_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    det_q |-> ($past(cnt_q) == QLAST)); // R4

  AST_NO_REDETECT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!armed_q && !rearm_i) |=> !det_q); // R7

endmodule

// File: rtl/oob_pattern_detector.sv
module oob_pattern_detector
  import oob_pkg::*;
#(
  parameter int unsigned BURST_MIN     = 2,
  parameter int unsigned INIT_GAP_MIN  = 12,
  parameter int unsigned INIT_GAP_MAX  = 36,
  parameter int unsigned WAKE_GAP_MIN  = 3,
  parameter int unsigned WAKE_GAP_MAX  = 10,
  parameter int unsigned RELEASE_QUIET = 40
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic line_active_i,
  output logic init_det_o,
  output logic wake_det_o,
  output logic release_o
);

  localparam int unsigned CNT_W = $clog2(RELEASE_QUIET + 1);

  logic             rst_n_s;
  run_evt_t         evt;
  logic [CNT_W-1:0] run_len;
  logic [NUM_PAT-1:0] det_vec;
  logic [NUM_PAT-1:0] armed_vec;
  logic             rel_fire;
  logic             rel_q;

  oob_rst_sync i_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_s)
  );

  oob_run_meter #(
    .CNT_MAX (RELEASE_QUIET),
    .QUIET   (RELEASE_QUIET),
    .CNT_W   (CNT_W)
  ) i_run_meter (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_s),
    .sig_i     (line_active_i),
    .evt_o     (evt),
    .run_len_o (run_len)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int unsigned LO = (p == int'(PAT_INIT)) ? INIT_GAP_MIN : WAKE_GAP_MIN;
    localparam int unsigned HI = (p == int'(PAT_INIT)) ? INIT_GAP_MAX : WAKE_GAP_MAX;

    oob_pattern_qual #(
      .CNT_W     (CNT_W),
      .GAP_MIN   (LO),
      .GAP_MAX   (HI),
      .BURST_MIN (BURST_MIN),
      .QUAL_N    (QUAL_BURSTS)
    ) i_qual (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_s),
      .burst_end_i (evt.burst_end),
      .idle_end_i  (evt.idle_end),
      .run_len_i   (run_len),
      .rearm_i     (rel_fire),
      .det_o       (det_vec[p]),
      .armed_o     (armed_vec[p])
    );
  end

  // next-state: release only matters once some pattern has fired
  always_comb begin
    rel_fire = evt.quiet_hit & (|(~armed_vec));
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rel_q <= 1'b0;
    end else begin
      rel_q <= rel_fire;
    end
  end

  assign init_det_o = det_vec[PAT_INIT];
  assign wake_det_o = det_vec[PAT_WAKE];
  assign release_o  = rel_q;

  AST_DET_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (init_det_o || wake_det_o) |-> !$past(line_active_i)); // R2

  AST_REL_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    release_o |-> !$past(line_active_i)); // R8

  AST_REL_EXCL_DET: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !(release_o && (init_det_o || wake_det_o))); // R8

  AST_REL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    release_o |=> !release_o); // R8

endmodule

// File: tb/test_oob_pattern_detector.sv
module test_oob_pattern_detector;

  localparam int BMIN = 2;
  localparam int IMIN = 12;
  localparam int IMAX = 36;
  localparam int WMIN = 3;
  localparam int WMAX = 14;   // overlaps the init window on 12..14
  localparam int QUIET = 40;
  localparam int QN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic line;
  logic init_det, wake_det, rel;

  always #4 clk = ~clk;

  oob_pattern_detector #(
    .BURST_MIN     (BMIN),
    .INIT_GAP_MIN  (IMIN),
    .INIT_GAP_MAX  (IMAX),
    .WAKE_GAP_MIN  (WMIN),
    .WAKE_GAP_MAX  (WMAX),
    .RELEASE_QUIET (QUIET)
  ) i_oob_pattern_detector (
    .clk_i         (clk),
    .rst_n_i       (rst_n),
    .line_active_i (line),
    .init_det_o    (init_det),
    .wake_det_o    (wake_det),
    .release_o     (rel)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_lvl;
  int m_run;
  int ci, cw;
  bit arm_i, arm_w;
  bit exp_i, exp_w, exp_r;

  function automatic bit in_win(input int g, input int lo, input int hi);
    return (g >= lo) && (g <= hi);
  endfunction

  task automatic model_reset();
    m_lvl = 1'b0; m_run = 1000000; ci = 0; cw = 0;
    arm_i = 1'b1; arm_w = 1'b1;
    exp_i = 1'b0; exp_w = 1'b0; exp_r = 1'b0;
  endtask

  task automatic model_step(input bit s);
    exp_i = 1'b0; exp_w = 1'b0; exp_r = 1'b0;
    if (s != m_lvl) begin
      if (m_lvl) begin
        if (m_run < BMIN) begin
          ci = 0; cw = 0;
        end else begin
          ci++; cw++;
          if (ci == QN && arm_i) begin exp_i = 1'b1; arm_i = 1'b0; end
          if (cw == QN && arm_w) begin exp_w = 1'b1; arm_w = 1'b0; end
        end
      end else begin
        if (!in_win(m_run, IMIN, IMAX)) ci = 0;
        if (!in_win(m_run, WMIN, WMAX)) cw = 0;
      end
      m_lvl = s;
      m_run = 1;
    end else begin
      if (m_run < 1000000) m_run++;
      if (!m_lvl && m_run == QUIET && (!arm_i || !arm_w)) begin
        exp_r = 1'b1; arm_i = 1'b1; arm_w = 1'b1; ci = 0; cw = 0;
      end
    end
  endtask

  task automatic compare(input bit ei, input bit ew, input bit er);
    vectors++;
    if ({init_det, wake_det, rel} !== {ei, ew, er}) begin
      fails++;
      $display("FAIL %s at %0t: actual init/wake/release=%b%b%b expected=%b%b%b",
               cur_req, $time, init_det, wake_det, rel, ei, ew, er);
    end
  endtask

  // one sample: drive, clock, predict, check away from the edge
  task automatic tick(input bit s);
    line = s;
    @(posedge clk);
    model_step(s);
    @(negedge clk);
    compare(exp_i, exp_w, exp_r);
  endtask

  task automatic burst(input int len);
    for (int k = 0; k < len; k++) tick(1'b1);
  endtask

  task automatic idle(input int len);
    for (int k = 0; k < len; k++) tick(1'b0);
  endtask

  // n bursts of length blen separated by gaps of length gap
  task automatic train(input int n, input int blen, input int gap);
    for (int k = 0; k < n; k++) begin
      burst(blen);
      if (k != n - 1) idle(gap);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    line = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    compare(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    idle(6);

    cur_req = "R2";                 // init pattern, then its release
    train(4, 4, 20); idle(2);
    cur_req = "R8"; idle(45);

    cur_req = "R3";                 // three bursts only, no release either
    train(3, 4, 20); idle(50);

    cur_req = "R4";                 // gap limits 12 and 36 accepted
    train(4, 3, IMIN); idle(1);
    idle(IMAX - 1); train(1, 3, 0); idle(IMIN); train(1, 3, 0);
    idle(45);
    cur_req = "R4";                 // 11 and 37 rejected, then restart
    train(2, 3, 20); idle(IMAX + 1); train(3, 3, 20); idle(IMIN - 1);
    train(3, 3, 20); idle(20); train(1, 3, 0); idle(45);

    cur_req = "R5";                 // wake pattern at both window limits
    train(4, 2, WMIN); idle(45);
    train(4, 2, 8); idle(45);
    train(2, 2, 5); idle(WMAX + 1); train(4, 2, WMAX); idle(45);

    cur_req = "R6";                 // short burst breaks the chain
    train(2, 3, 20); idle(20); burst(1); idle(20); train(3, 3, 20); idle(45);
    train(2, 3, 20); idle(20); burst(1); idle(20); train(4, 3, 20); idle(45);

    cur_req = "R7";                 // qualifying bursts after a detect are silent
    train(4, 3, 20); idle(20); train(5, 3, 20); idle(45);
    train(4, 3, 20); idle(45);

    cur_req = "R9";                 // idle beyond counter range
    train(3, 3, 20); idle(84); train(1, 3, 0); idle(84); train(2, 3, 20); idle(50);

    cur_req = "R10";                // overlap window: both fire together
    train(4, 3, 13); idle(45);

    cur_req = "R2/R5/R8 random";
    for (int n = 0; n < 300; n++) begin
      int sel, g;
      burst(1 + int'($urandom % 6));
      sel = int'($urandom % 4);
      case (sel)
        0: g = 3 + int'($urandom % 12);
        1: g = 12 + int'($urandom % 25);
        2: g = 1 + int'($urandom % 50);
        default: g = 40 + int'($urandom % 61);
      endcase
      idle(g);
    end
    idle(45);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule